// File: doc/BRIEF.md
# Configuration Frame Address Sequencer

This block keeps the 32-bit configuration frame address while a configuration port streams frame data into the device. A register write loads a starting address. After that, every accepted 32-bit data word is counted. When a frame of 101 words is complete, the block pulses a strobe. It then moves the address to the next frame, stepping the minor index, the column and the row in turn. A downstream memory writer uses the current address to steer each frame into the right place.

Columns do not all hold the same number of frames. The block therefore shows its current column on `cur_addr_o` and reads the frame count for that column back from an external lookup on `frame_cnt_i`. When a row's last column finishes, the block expects two frames made only of zeros. During those frames it raises a padding flag and reports any non-zero word. The row then advances and the column returns to zero. An input can turn off the automatic advance, so that every frame is written to the same address.

Top module: `cfg_frame_seq`

## Requirements
- R1: While reset is held, `cur_addr_o` is 0 and `frame_done_o`, `pad_o` and `pad_err_o` are low.
- R2: When `load_i` is high, `cur_addr_o` takes `load_addr_i` on the next clock edge, and the word count and padding state are cleared. A data word offered in the same cycle as a load is not counted.
- R3: `frame_done_o` is high for exactly one cycle, in the cycle after the 101st accepted word of a frame, counted from the last load.
- R4: At the end of a frame outside padding, with auto-advance on and minor+1 below `frame_cnt_i`, the minor field (bits 6:0) increments by one.
- R5: At the end of a frame outside padding, with auto-advance on and minor+1 at or above `frame_cnt_i`, minor returns to 0 and the column field (bits 16:7) increments. The exception is the last column, which is `LAST_COL`.
- R6: When the last column wraps, the address keeps its column with minor 0 and `pad_o` rises. `pad_o` stays high for exactly two frames. At the end of the second frame, the row field (bits 21:17) increments and column and minor become 0.
- R7: An accepted non-zero word during padding makes `pad_err_o` high for the following cycle. Zero words during padding, and any word outside padding, leave `pad_err_o` low.
- R8: When `autoinc_dis_i` is high at the end of a non-padding frame, the address is unchanged and padding is not entered.
- R9: Advancing never changes bits 31:22, which hold the reserved bits, the bus type and the half bit. Row 31 steps to row 0.
- R10: Cycles with `word_vld_i` low do not count toward a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load start address |
| load_addr_i | input | 32 | Start frame address |
| word_vld_i | input | 1 | Data word valid |
| word_i | input | 32 | Data word |
| autoinc_dis_i | input | 1 | Hold address at frame end |
| frame_cnt_i | input | 7 | Frame count of the column in `cur_addr_o` |
| cur_addr_o | output | 32 | Current frame address |
| frame_done_o | output | 1 | One-cycle strobe after a complete frame |
| pad_o | output | 1 | Row-end padding frames in progress |
| pad_err_o | output | 1 | Non-zero word seen during padding |

## Verification
Some rules are checked by assertions on every cycle:
- `frame_done_o` is a single-cycle pulse.
- The address stays stable between frame ends and loads.
- The upper ten address bits are preserved while the address advances.
- Minor is zero while padding is in progress.
- An error pulse occurs only during padding.
- The address is held when auto-advance is off.

Other behaviour is shown only by the bench's scenarios against its own model:
- the exact 101-word count and the handling of word gaps;
- the minor and column roll-over driven by the lookup;
- the two-frame padding length followed by the row step;
- the row wrap from 31 to 0;
- a load arriving in the middle of a frame or in the same cycle as a word.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned MINOR_W = 7;
  localparam int unsigned COL_W   = 10;
  localparam int unsigned ROW_W   = 5;

  typedef struct packed {
    logic [5:0]         rsvd;
    logic [2:0]         bus;
    logic               half;
    logic [ROW_W-1:0]   row;
    logic [COL_W-1:0]   col;
    logic [MINOR_W-1:0] minor;
  } frame_addr_t;
endpackage

// File: rtl/cfg_word_ctr.sv
module cfg_word_ctr #(
  parameter int unsigned WORDS = 101,
  localparam int unsigned CW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic vld_i,
  output logic frame_end_o
);
  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last     = (cnt_q == CW'(WORDS - 1));
  assign frame_end_o = vld_i && !clr_i && at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (vld_i)  cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfg_pad_ctl.sv
module cfg_pad_ctl #(
  parameter int unsigned PAD_FRAMES = 2,
  parameter int unsigned DW = 32,
  localparam int unsigned PW = (PAD_FRAMES > 1) ? $clog2(PAD_FRAMES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          enter_i,
  input  logic          frame_end_i,
  input  logic          vld_i,
  input  logic [DW-1:0] word_i,
  output logic          pad_o,
  output logic          exit_o,
  output logic          err_o
);
  logic          pad_q;
  logic [PW-1:0] pcnt_q;
  logic          err_q;

  assign pad_o  = pad_q;
  assign err_o  = err_q;
  assign exit_o = pad_q && frame_end_i && (pcnt_q == PW'(PAD_FRAMES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pad_q  <= 1'b0;
      pcnt_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= vld_i && !clr_i && pad_q && (word_i != '0);
      if (clr_i) begin
        pad_q  <= 1'b0;
        pcnt_q <= '0;
      end else if (enter_i) begin
        pad_q  <= 1'b1;
        pcnt_q <= '0;
      end else if (exit_o) begin
        pad_q  <= 1'b0;
        pcnt_q <= '0;
      end else if (pad_q && frame_end_i) begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_addr_adv.sv
module cfg_addr_adv
  import cfg_seq_pkg::*;
#(
  parameter int unsigned LAST_COL = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [ADDR_W-1:0]  load_addr_i,
  input  logic               frame_end_i,
  input  logic               autoinc_dis_i,
  input  logic [MINOR_W-1:0] frame_cnt_i,
  input  logic               pad_i,
  input  logic               pad_exit_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               enter_pad_o
);
  frame_addr_t addr_q, addr_d;
  logic        minor_wrap;

  // count of 0 behaves like 1; minor beyond count also wraps
  assign minor_wrap = ({1'b0, addr_q.minor} + 1'b1) >= {1'b0, frame_cnt_i};

  always_comb begin
    addr_d      = addr_q;
    enter_pad_o = 1'b0;
    if (load_i) begin
      addr_d = frame_addr_t'(load_addr_i);
    end else if (frame_end_i) begin
      if (pad_exit_i) begin
        addr_d.row   = addr_q.row + 1'b1;
        addr_d.col   = '0;
        addr_d.minor = '0;
      end else if (!pad_i && !autoinc_dis_i) begin
        if (minor_wrap) begin
          addr_d.minor = '0;
          if (addr_q.col == COL_W'(LAST_COL)) enter_pad_o = 1'b1;
          else                                addr_d.col = addr_q.col + 1'b1;
        end else begin
          addr_d.minor = addr_q.minor + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/cfg_frame_seq.sv
module cfg_frame_seq
  import cfg_seq_pkg::*;
#(
  parameter int unsigned WORDS_PER_FRAME = 101,
  parameter int unsigned PAD_FRAMES      = 2,
  parameter int unsigned LAST_COL        = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [ADDR_W-1:0]  load_addr_i,
  input  logic               word_vld_i,
  input  logic [31:0]        word_i,
  input  logic               autoinc_dis_i,
  input  logic [MINOR_W-1:0] frame_cnt_i,
  output logic [ADDR_W-1:0]  cur_addr_o,
  output logic               frame_done_o,
  output logic               pad_o,
  output logic               pad_err_o
);
  logic acc_vld, frame_end, enter_pad, pad_exit, pad_act, done_q;

  assign acc_vld = word_vld_i && !load_i;

  cfg_word_ctr #(.WORDS(WORDS_PER_FRAME)) u_wctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(load_i), .vld_i(acc_vld),
    .frame_end_o(frame_end)
  );

  cfg_pad_ctl #(.PAD_FRAMES(PAD_FRAMES), .DW(32)) u_pad (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(load_i), .enter_i(enter_pad),
    .frame_end_i(frame_end), .vld_i(acc_vld), .word_i(word_i),
    .pad_o(pad_act), .exit_o(pad_exit), .err_o(pad_err_o)
  );

  cfg_addr_adv #(.LAST_COL(LAST_COL)) u_adv (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .load_addr_i(load_addr_i),
    .frame_end_i(frame_end), .autoinc_dis_i(autoinc_dis_i),
    .frame_cnt_i(frame_cnt_i), .pad_i(pad_act), .pad_exit_i(pad_exit),
    .addr_o(cur_addr_o), .enter_pad_o(enter_pad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= frame_end;
  end

  assign frame_done_o = done_q;
  assign pad_o        = pad_act;
endmodule

// File: rtl/cfg_frame_seq_chk.sv
module cfg_frame_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        load_i,
  input logic        autoinc_dis_i,
  input logic [31:0] cur_addr_o,
  input logic        frame_done_o,
  input logic        pad_o,
  input logic        pad_err_o
);
  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  // R10
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_done_o && !$past(load_i)) |-> $stable(cur_addr_o));

  // R9
  upper_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> $stable(cur_addr_o[31:22]));

  // R6
  pad_minor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_o && !$past(load_i)) |-> (cur_addr_o[6:0] == 7'd0));

  // R7
  err_in_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_err_o |-> $past(pad_o));

  // R8
  dis_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_o && $past(autoinc_dis_i) && !$past(pad_o) && !$past(load_i))
      |-> $stable(cur_addr_o));
endmodule

bind cfg_frame_seq cfg_frame_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i),
  .autoinc_dis_i(autoinc_dis_i), .cur_addr_o(cur_addr_o),
  .frame_done_o(frame_done_o), .pad_o(pad_o), .pad_err_o(pad_err_o)
);

// File: tb/sim_cfg_frame_seq.sv
module sim_cfg_frame_seq;
  localparam int WPF = 101;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0, word_vld_i = 1'b0, autoinc_dis_i = 1'b0;
  logic [31:0] load_addr_i = '0, word_i = '0;
  logic [6:0]  frame_cnt_i;
  logic [31:0] cur_addr_o;
  logic        frame_done_o, pad_o, pad_err_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // expected state
  logic [31:0] e_addr = '0;
  int          e_wc = 0, e_pc = 0;
  bit          e_pad = 0, e_fd = 0, e_err = 0;
  string       tag = "R1";

  always #10 clk_i = ~clk_i;

  function automatic logic [6:0] col_frames(input logic [9:0] c);
    return c[0] ? 7'd3 : 7'd2;
  endfunction

  assign frame_cnt_i = col_frames(cur_addr_o[16:7]);

  cfg_frame_seq u0 (.*);

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic model(input bit ld, input logic [31:0] la, input bit v,
                       input logic [31:0] w, input bit dis);
    logic [6:0] cnt;
    e_fd = 0;
    if (ld) begin
      e_addr = la; e_wc = 0; e_pad = 0; e_pc = 0; e_err = 0; tag = "R2";
      return;
    end
    e_err = v && e_pad && (w != 0);
    tag = "R10";
    if (!v) return;
    if (e_wc != WPF - 1) begin e_wc++; return; end
    e_wc = 0; e_fd = 1;
    if (e_pad) begin
      tag = "R6";
      if (e_pc == 1) begin
        e_pad = 0; e_pc = 0;
        e_addr[21:17] = e_addr[21:17] + 5'd1;
        e_addr[16:0] = '0;
      end else e_pc++;
    end else if (dis) begin
      tag = "R8";
    end else begin
      cnt = col_frames(e_addr[16:7]);
      if ({1'b0, e_addr[6:0]} + 8'd1 >= {1'b0, cnt}) begin
        e_addr[6:0] = '0;
        if (e_addr[16:7] == 10'd3) begin e_pad = 1; e_pc = 0; tag = "R6"; end
        else begin e_addr[16:7] = e_addr[16:7] + 10'd1; tag = "R5"; end
      end else begin
        e_addr[6:0] = e_addr[6:0] + 7'd1; tag = "R4";
      end
    end
  endtask

  task automatic step(input bit ld, input logic [31:0] la, input bit v,
                      input logic [31:0] w, input bit dis);
    load_i = ld; load_addr_i = la; word_vld_i = v; word_i = w; autoinc_dis_i = dis;
    @(posedge clk_i);
    model(ld, la, v, w, dis);
    @(negedge clk_i);
    chk(tag, cur_addr_o, e_addr);
    chk("R3", {31'b0, frame_done_o}, {31'b0, e_fd});
    chk("R6", {31'b0, pad_o}, {31'b0, e_pad});
    chk("R7", {31'b0, pad_err_o}, {31'b0, e_err});
  endtask

  task automatic frame(input bit dis, input int nz_at);
    for (int k = 0; k < WPF; k++) step(0, '0, 1, (k == nz_at) ? 32'h1 : 32'h0, dis);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    // R1 reset values
    chk("R1", cur_addr_o, 32'h0);
    chk("R1", {29'b0, frame_done_o, pad_o, pad_err_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9 row 31 wrap with bus 001, half 1, last column, last minor
    step(1, {6'h2A, 3'b001, 1'b1, 5'd31, 10'd3, 7'd2}, 0, '0, 0);
    frame(0, -1);                 // enters padding
    frame(0, 7);                  // R7 non-zero during padding
    frame(0, -1);                 // R6 exit padding, row wraps
    chk("R9", cur_addr_o, {6'h2A, 3'b001, 1'b1, 5'd0, 10'd0, 7'd0});

    // R2 load mid-frame, and load together with a word
    for (int k = 0; k < 50; k++) step(0, '0, 1, $urandom, 0);
    step(1, {15'b0, 10'd1, 7'd0}, 1, 32'hFFFF_FFFF, 0);
    frame(0, -1);
    chk("R4", cur_addr_o, {15'b0, 10'd1, 7'd1});

    // R8 auto-advance off at a column end
    step(1, {15'b0, 10'd0, 7'd1}, 0, '0, 0);
    frame(1, -1);
    chk("R8", cur_addr_o, {15'b0, 10'd0, 7'd1});
    frame(0, -1);
    chk("R5", cur_addr_o, {15'b0, 10'd1, 7'd0});

    // R10 gaps in the stream
    for (int k = 0; k < 30; k++) step(0, '0, k[0], 32'h5, 0);

    // random mix
    begin
      bit dis = 0;
      for (int i = 0; i < 40000; i++) begin
        bit ld = ($urandom_range(0, 499) == 0);
        logic [31:0] la = $urandom;
        logic [31:0] w;
        la[16:7] = 10'($urandom_range(0, 3));
        la[6:0] = 7'($urandom_range(0, 2));
        if (e_wc == 0) dis = ($urandom_range(0, 7) == 0);
        w = e_pad ? (($urandom_range(0, 60) == 0) ? ($urandom | 32'h1) : 32'h0) : $urandom;
        step(ld, la, ($urandom_range(0, 3) != 0), w, dis);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule